// File: doc/BRIEF.md
# Asynchronous Byte Port with Strobe-Recovery Flags

This block is the device half of a byte-wide port that an outside agent works with two active-low strobes, one for reading and one for writing, with no clock shared between them. Internally it keeps a receive queue, filled by on-chip logic over a valid/ready port, and a transmit queue, drained by on-chip logic over a second valid/ready port. Two active-low flags tell the agent when a byte can be fetched and when a byte can be delivered.

Both strobes are brought into the internal clock domain through a chain of synchronizing flops, and their edges are detected there. When a strobe is accepted, its flag is driven inactive. The flag stays inactive for a programmable recovery interval after the strobe is released, even when the queue could serve another byte at once. The byte on offer sits on the output data lines for as long as the read strobe is held. Write data is latched by the strobe's own rising edge, so the short hold window at the pins is met. A strobe that arrives while its flag is inactive is dropped, and the drop is recorded in a sticky error output.

Top module: `async_byte_port`

## Requirements
- R1: `bus_oe_n_o` always carries the same level as `rd_n_i`, with no clocked delay.
- R2: While `bus_oe_n_o` is low, `bus_dout_o` equals the oldest byte held in the receive queue. While it is high, `bus_dout_o` is all zeros.
- R3: `avail_n_o` is low only when the receive queue holds at least one byte. After an accepted read strobe (a falling edge seen while `avail_n_o` was low), the flag is high while the strobe is held. Releasing the strobe removes exactly one byte from the receive queue.
- R4: After an accepted strobe is released, its flag (`avail_n_o` for reads, `room_n_o` for writes) stays high for at least RECOVERY_CYCLES+1 clock cycles.
- R5: `room_n_o` is low only when the transmit queue has a free slot. It is high while an accepted write strobe is held low.
- R6: The byte on `bus_din_i` at the rising edge of `wr_n_i` closes an accepted write. That byte enters the transmit queue and leaves on `tx_out_data_o` in arrival order, one byte per cycle in which `tx_out_valid_o` and `tx_out_ready_i` are both high.
- R7: `rx_in_ready_o` is low exactly when the receive queue is full. Bytes taken on the receive port are presented to the agent in arrival order.
- R8: A read strobe whose falling edge is seen while `avail_n_o` is high removes no byte. It sets `proto_err_o`, which stays high until reset.
- R9: A write strobe whose falling edge is seen while `room_n_o` is high adds no byte and sets `proto_err_o`.
- R10: During reset, `avail_n_o` and `room_n_o` are high, `proto_err_o` and `tx_out_valid_o` are low, and `rx_in_ready_o` is high. Within two clocks after reset, `room_n_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n_i | input | 1 | Read strobe from the agent, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe from the agent, active low, asynchronous |
| bus_din_i | input | DATA_W | Byte driven by the agent during a write |
| bus_dout_o | output | DATA_W | Byte offered to the agent during a read |
| bus_oe_n_o | output | 1 | Active-low enable for the external data drivers |
| avail_n_o | output | 1 | Active low: a byte may be read |
| room_n_o | output | 1 | Active low: a byte may be written |
| proto_err_o | output | 1 | Sticky: a strobe came while its flag was inactive |
| rx_in_valid_i | input | 1 | On-chip source offers a byte for the receive queue |
| rx_in_data_i | input | DATA_W | Byte from the on-chip source |
| rx_in_ready_o | output | 1 | Receive queue can take a byte |
| tx_out_valid_o | output | 1 | Transmit queue holds a byte |
| tx_out_data_o | output | DATA_W | Oldest byte of the transmit queue |
| tx_out_ready_i | input | 1 | On-chip sink takes the byte |

## Verification
Two pairs of functions can land in the same clock cycle. On the receive queue, a pop caused by a released read strobe can meet a push from the on-chip source. On the transmit queue, a push caused by a released write strobe can meet a pop by the sink. The bench provokes the first pair by running a source that keeps offering bytes while a reader works through them, and the second by writing while the sink's ready toggles. It judges both by scoreboard order: every byte seen at the pins or at the sink must match the head of the expected queue, and no byte may be lost or duplicated.

// File: rtl/afp_pkg.sv
package afp_pkg;
   localparam int unsigned AFP_MIN_SYNC = 2;

   typedef struct packed {
      logic fall;
      logic rise;
   } afp_edge_t;
endpackage

// File: rtl/afp_sync.sv
module afp_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= afp_pkg::AFP_MIN_SYNC)
         else $error("afp_sync: STAGES below minimum");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/afp_queue.sv
module afp_queue #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pop_i,
   output logic [W-1:0] head_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr, rd_ptr;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("afp_queue: DEPTH must be a power of two, at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + 1'b1;
         if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_ptr[AW-1:0]] <= wdata_i;
   end

   assign head_o  = mem[rd_ptr[AW-1:0]];
   assign empty_o = (wr_ptr == rd_ptr);
   assign full_o  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);

   // R6 / R7: the port logic never pushes into a full queue
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R3: a released read never pops an empty queue
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
endmodule

// File: rtl/afp_strobe_ctl.sv
module afp_strobe_ctl #(
   parameter int unsigned REC_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic ready_i,
   output logic flag_n_o,
   output logic done_o,
   output logic err_o
);
   localparam int unsigned CW = $clog2(REC_CYCLES + 1);

   afp_pkg::afp_edge_t edg;
   logic          act_q;
   logic          in_xfer;
   logic [CW-1:0] rec_cnt;
   logic          flag_n_q;
   logic          err_q;

   initial begin
      assert (REC_CYCLES >= 1) else $error("afp_strobe_ctl: REC_CYCLES must be >= 1");
   end

   assign edg.fall = act_i & ~act_q;
   assign edg.rise = ~act_i & act_q;
   assign done_o   = edg.rise & in_xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         in_xfer  <= 1'b0;
         rec_cnt  <= '0;
         flag_n_q <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         act_q <= act_i;
         if (edg.fall)      in_xfer <= ~flag_n_q;
         else if (edg.rise) in_xfer <= 1'b0;
         if (done_o)              rec_cnt <= CW'(REC_CYCLES);
         else if (rec_cnt != '0)  rec_cnt <= rec_cnt - 1'b1;
         if (edg.fall && flag_n_q) err_q <= 1'b1;
         flag_n_q <= ~(ready_i && !act_i && !in_xfer && rec_cnt == '0);
      end
   end

   assign flag_n_o = flag_n_q;
   assign err_o    = err_q;

   // R3 / R5: an accepted strobe turns its flag inactive on the next clock
   p_accept_drops_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edg.fall && !flag_n_q) |=> flag_n_q);
   // R4: release of an accepted strobe loads the recovery window, flag held
   p_recovery_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (flag_n_q && rec_cnt == CW'(REC_CYCLES)));
   // R4: flag held inactive during the whole window
   p_recovery_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_cnt != '0) |-> flag_n_q);
   // R3 / R5: active flag only when the queue could serve
   p_flag_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_n_q |-> $past(ready_i));
   // R8: error is sticky
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/async_byte_port.sv
module async_byte_port #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned RX_DEPTH        = 16,
   parameter int unsigned TX_DEPTH        = 16,
   parameter int unsigned RECOVERY_CYCLES = 10,
   parameter int unsigned SYNC_STAGES     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic [DATA_W-1:0] bus_din_i,
   output logic [DATA_W-1:0] bus_dout_o,
   output logic              bus_oe_n_o,
   output logic              avail_n_o,
   output logic              room_n_o,
   output logic              proto_err_o,
   input  logic              rx_in_valid_i,
   input  logic [DATA_W-1:0] rx_in_data_i,
   output logic              rx_in_ready_o,
   output logic              tx_out_valid_o,
   output logic [DATA_W-1:0] tx_out_data_o,
   input  logic              tx_out_ready_i
);
   logic rd_s, wr_s;
   logic rd_done, wr_done;
   logic rd_err, wr_err;
   logic rx_empty, rx_full, tx_empty, tx_full;
   logic [DATA_W-1:0] rx_head;
   logic [DATA_W-1:0] wr_hold;

   afp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rd_n_i), .q_o(rd_s));
   afp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .d_i(wr_n_i), .q_o(wr_s));

   // write data is latched by the strobe itself; it is stable long before
   // the synchronized release triggers the push
   always_ff @(posedge wr_n_i) begin
      wr_hold <= bus_din_i;
   end

   afp_strobe_ctl #(.REC_CYCLES(RECOVERY_CYCLES)) u_rd_ctl (
      .clk(clk), .rst_n(rst_n), .act_i(~rd_s), .ready_i(~rx_empty),
      .flag_n_o(avail_n_o), .done_o(rd_done), .err_o(rd_err));
   afp_strobe_ctl #(.REC_CYCLES(RECOVERY_CYCLES)) u_wr_ctl (
      .clk(clk), .rst_n(rst_n), .act_i(~wr_s), .ready_i(~tx_full),
      .flag_n_o(room_n_o), .done_o(wr_done), .err_o(wr_err));

   afp_queue #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push_i(rx_in_valid_i & ~rx_full), .wdata_i(rx_in_data_i),
      .pop_i(rd_done), .head_o(rx_head),
      .empty_o(rx_empty), .full_o(rx_full));
   afp_queue #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push_i(wr_done), .wdata_i(wr_hold),
      .pop_i(tx_out_ready_i & ~tx_empty), .head_o(tx_out_data_o),
      .empty_o(tx_empty), .full_o(tx_full));

   assign rx_in_ready_o  = ~rx_full;
   assign tx_out_valid_o = ~tx_empty;
   assign bus_oe_n_o     = rd_n_i;
   assign bus_dout_o     = rd_n_i ? '0 : rx_head;
   assign proto_err_o    = rd_err | wr_err;

   // R9: combined error output never clears outside reset
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o);
   // R5: write flag active only with a free transmit slot
   p_room_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !room_n_o |-> !tx_full || $past(!tx_full));
endmodule

// File: tb/async_byte_port_bench.sv
module async_byte_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int DEP = 4;
   localparam int REC = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rd_n = 1'b1, wr_n = 1'b1;
   logic [DW-1:0] din = '0, dout;
   logic oe_n, av_n, rm_n, perr;
   logic rxv = 1'b0, rxr;
   logic [DW-1:0] rxd = '0;
   logic txv, txr = 1'b0;
   logic [DW-1:0] txd;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] exp_rx[$];
   logic [DW-1:0] exp_tx[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   async_byte_port #(.DATA_W(DW), .RX_DEPTH(DEP), .TX_DEPTH(DEP),
                     .RECOVERY_CYCLES(REC), .SYNC_STAGES(2)) u_async_byte_port (
      .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .bus_din_i(din), .bus_dout_o(dout), .bus_oe_n_o(oe_n),
      .avail_n_o(av_n), .room_n_o(rm_n), .proto_err_o(perr),
      .rx_in_valid_i(rxv), .rx_in_data_i(rxd), .rx_in_ready_o(rxr),
      .tx_out_valid_o(txv), .tx_out_data_o(txd), .tx_out_ready_i(txr));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

   // scoreboard monitor for the transmit sink (R6)
   initial begin
      forever begin
         @(negedge clk); #1;
         if (txv && txr) begin
            if (exp_tx.size() == 0) check(1'b0, "R6 extra byte", txd, 0);
            else begin
               logic [DW-1:0] e;
               e = exp_tx.pop_front();
               check(txd == e, "R6 order", txd, e);
            end
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; rxv = 1'b0; txr = 1'b0;
      exp_rx.delete(); exp_tx.delete();
      repeat (3) @(negedge clk);
      check(av_n == 1'b1, "R10 avail_n in reset", av_n, 1);
      check(rm_n == 1'b1, "R10 room_n in reset", rm_n, 1);
      check(perr == 1'b0, "R10 err in reset", perr, 0);
      check(txv == 1'b0, "R10 tx valid in reset", txv, 0);
      check(rxr == 1'b1, "R10 rx ready in reset", rxr, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(rm_n == 1'b0, "R10 room_n after reset", rm_n, 0);
   endtask

   task automatic src_push(input logic [DW-1:0] b);
      bit done = 0;
      while (!done) begin
         @(negedge clk);
         rxv = 1'b1; rxd = b;
         #1;
         if (rxr) begin exp_rx.push_back(b); done = 1; end
      end
      @(negedge clk);
      rxv = 1'b0;
   endtask

   task automatic wait_flag_low(input bit rd);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if ((rd ? av_n : rm_n) == 1'b0) break;
      end
   endtask

   task automatic agent_read(input bit chk_rec);
      logic [DW-1:0] e;
      int n;
      wait_flag_low(1);
      rd_n = 1'b0; #1;
      check(oe_n == 1'b0, "R1 oe low with strobe", oe_n, 0);
      repeat (5) @(negedge clk);
      e = exp_rx.pop_front();
      check(dout == e, "R2 byte on bus", dout, e);
      check(av_n == 1'b1, "R3 avail_n high in strobe", av_n, 1);
      rd_n = 1'b1; #1;
      check(oe_n == 1'b1, "R1 oe high after strobe", oe_n, 1);
      check(dout == '0, "R2 bus zero when idle", dout, 0);
      if (chk_rec) begin
         n = 0;
         for (int i = 1; i <= 40; i++) begin
            @(negedge clk); n = i;
            if (av_n == 1'b0) break;
         end
         check(n >= REC + 1 && av_n == 1'b0, "R4 read recovery", n, REC + 1);
      end
   endtask

   task automatic agent_write(input logic [DW-1:0] b, input bit chk_rec);
      int n;
      wait_flag_low(0);
      din = b; wr_n = 1'b0;
      repeat (5) @(negedge clk);
      check(rm_n == 1'b1, "R5 room_n high in strobe", rm_n, 1);
      wr_n = 1'b1;
      exp_tx.push_back(b);
      @(negedge clk);
      din = ~b;
      if (chk_rec) begin
         n = 1;
         for (int i = 2; i <= 40; i++) begin
            if (rm_n == 1'b0) break;
            @(negedge clk); n = i;
         end
         check(n >= REC + 1 && rm_n == 1'b0, "R4 write recovery", n, REC + 1);
      end
   endtask

   task automatic raw_strobe(input bit rd);
      if (rd) rd_n = 1'b0; else wr_n = 1'b0;
      repeat (5) @(negedge clk);
      if (rd) rd_n = 1'b1; else wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      do_reset();

      // R7: fill the receive queue, order and full flag
      for (int i = 0; i < DEP; i++) src_push(8'h10 + 8'(i));
      #1;
      check(rxr == 1'b0, "R7 rx ready low when full", rxr, 0);
      check(dout == '0, "R2 bus zero before read", dout, 0);
      for (int i = 0; i < DEP; i++) agent_read(i < DEP - 1);
      repeat (30) @(negedge clk);
      check(av_n == 1'b1, "R3 avail_n high when empty", av_n, 1);
      check(perr == 1'b0, "R8 no error on legal reads", perr, 0);

      // R3/R7: source pushes while reads pop (same-cycle push/pop)
      fork
         for (int i = 0; i < 9; i++) src_push(8'hA0 ^ 8'(i * 37));
         for (int i = 0; i < 9; i++) agent_read(0);
      join
      check(exp_rx.size() == 0, "R7 all bytes read", exp_rx.size(), 0);

      // R6: writes with the sink toggling
      txr = 1'b1;
      agent_write(8'h5A, 1);
      agent_write(8'hC3, 0);
      txr = 1'b0;
      agent_write(8'h01, 0);
      txr = 1'b1;
      agent_write(8'hFE, 0);
      repeat (10) @(negedge clk);
      check(exp_tx.size() == 0, "R6 all writes drained", exp_tx.size(), 0);

      // R8: read strobe during recovery is ignored and flagged
      do_reset();
      src_push(8'h77);
      src_push(8'h88);
      agent_read(0);
      @(negedge clk);
      check(perr == 1'b0, "R8 no error yet", perr, 0);
      raw_strobe(1);
      check(perr == 1'b1, "R8 error set", perr, 1);
      agent_read(0);
      repeat (30) @(negedge clk);
      check(av_n == 1'b1, "R8 no byte lost or extra", av_n, 1);
      check(perr == 1'b1, "R8 error sticky", perr, 1);

      // R9: write strobe into a full transmit queue is ignored
      do_reset();
      for (int i = 0; i < DEP; i++) agent_write(8'h30 + 8'(i), 0);
      repeat (20) @(negedge clk);
      check(rm_n == 1'b1, "R5 room_n high when full", rm_n, 1);
      din = 8'hEE;
      raw_strobe(0);
      check(perr == 1'b1, "R9 error set", perr, 1);
      txr = 1'b1;
      repeat (DEP + 6) @(negedge clk);
      check(exp_tx.size() == 0, "R9 queued bytes drained", exp_tx.size(), 0);
      check(txv == 1'b0, "R9 ignored byte absent", txv, 0);

      report();
      $finish;
   end
endmodule